// File: doc/BRIEF.md
# Load/Store Queue with Memory Disambiguation

This block holds the memory instructions of an out-of-order core in program order. It records each effective address once the address arithmetic has finished, and it decides in which cycle each load may read memory. A store never touches memory early. It writes only when it is the oldest entry, both its address and its data are present, and the retirement logic asserts commit. A single memory request port carries both store writes and load reads, and the port takes one request per cycle.

The block has two policies, chosen by `predict_mode_i`. In the safe policy a load waits until every older store has a known address that differs from its own. In the speculative policy a load ignores older stores whose address is still unknown. If one of those stores later resolves to the load's address, the queue flags the load for replay and clears its completion. The load then reads again once that store has written memory. Addresses are compared across their full width. Entries retire in order.

Top module: `load_store_queue`

## Requirements
- R1: Entries are handed out in program order. `alloc_idx_o` starts at 0 after reset and steps by one modulo DEPTH on each accepted allocation. `full_o` is 1 when DEPTH entries are live, and an allocation requested while `full_o` is 1 is dropped and creates no entry.
- R2: If the address operand of a load with no conflict is presented in the cycle ending at clock edge n, the load's read request appears after edge n+1. The read request has `mem_valid_o`=1, `mem_write_o`=0, the stored address and the entry index.
- R3: A store issues its write only when it is at the head, its address and data are both known, and `commit_i` is 1. The write request has `mem_write_o`=1 and appears after the edge that samples that `commit_i`, and `commit_done_o` is 1 in that cycle. A head store that lacks its data does not retire and issues no write.
- R4: In the safe policy (`predict_mode_i`=0), a load issues no read while any older store has an unknown address. It becomes eligible in the cycle after the last such address is written.
- R5: In the safe policy, a load whose address equals that of an older store waits until that store's write request has been issued. Its read follows one cycle after that write.
- R6: In the speculative policy (`predict_mode_i`=1), a load whose older stores all have unknown addresses reads with the timing of R2.
- R7: In the speculative policy, when an older store's address is written and equals the address of a load that has already read, bit i of `replay_mask_o` (i being the load's entry index) is 1 for exactly one cycle, starting after the edge that stores the address. The load then reads again one cycle after that store's write request.
- R8: At most one request is issued per cycle, and a committing store write takes the port before any load. Among eligible loads the oldest reads first, and the others follow in the next cycles in age order.
- R9: A load at the head retires on `commit_i` only after it has issued its read. Otherwise `commit_done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| predict_mode_i | input | 1 | 0 = wait for older store addresses, 1 = speculate and replay |
| alloc_i | input | 1 | Allocate one entry at the tail |
| alloc_store_i | input | 1 | Allocated entry is a store (1) or a load (0) |
| alloc_idx_o | output | IDX_W | Index the next allocation receives |
| full_o | output | 1 | All entries occupied |
| addr_valid_i | input | 1 | Address operand available for an entry |
| addr_idx_i | input | IDX_W | Entry receiving the address |
| addr_i | input | ADDR_W | Effective address |
| data_valid_i | input | 1 | Store data available for an entry |
| data_idx_i | input | IDX_W | Store entry whose data is ready |
| commit_i | input | 1 | Retirement permits the head entry to leave |
| commit_done_o | output | 1 | Head entry retires this cycle |
| mem_valid_o | output | 1 | Memory request issued |
| mem_write_o | output | 1 | Request is a store write (1) or a load read (0) |
| mem_addr_o | output | ADDR_W | Request address |
| mem_idx_o | output | IDX_W | Queue entry that owns the request |
| replay_mask_o | output | DEPTH | One bit per entry, load must be re-executed |

## Verification
The embedded properties assume a well-behaved environment. Allocation is requested only when the queue has room. `predict_mode_i` changes only while the queue is empty. Each address and data update names a live entry that has not yet received that item. The stimulus follows these rules. The mode is switched only after every entry has retired, and each entry gets its address and data once. The one allocation made while full is there to exercise the drop path at the ports. The entry-level pointer property does not constrain that case, because the top gates the request before it reaches the pointers.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef struct packed {
    logic valid;
    logic is_store;
    logic addr_known;
    logic data_known;
    logic done;
  } lsq_flags_t;
endpackage

// File: rtl/lsq_ptrs.sv
module lsq_ptrs #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [IDX_W:0]   count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop_i)  head_q <= head_q + 1'b1;
      count_q <= count_q + (IDX_W+1)'(push_i) - (IDX_W+1)'(pop_i);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign full_o = (count_q == (IDX_W+1)'(DEPTH));

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
endmodule

// File: rtl/lsq_pick.sv
module lsq_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] head_i,
  input  logic [DEPTH-1:0] req_i,
  output logic [DEPTH-1:0] gnt_o,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  // oldest-first scan starting at the head
  always_comb begin
    logic [IDX_W-1:0] idx;
    gnt_o       = '0;
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_i + IDX_W'(k);
      if (!gnt_valid_o && req_i[idx]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = idx;
        gnt_o[idx]  = 1'b1;
      end
    end
  end

  // R8
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
endmodule

// File: rtl/lsq_hazard.sv
module lsq_hazard #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int ADDR_W = 32
) (
  input  logic [IDX_W-1:0]              head_i,
  input  logic [DEPTH-1:0]              valid_i,
  input  logic [DEPTH-1:0]              store_i,
  input  logic [DEPTH-1:0]              addr_known_i,
  input  logic [DEPTH-1:0]              done_i,
  input  logic [DEPTH-1:0]              issue_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  addr_i,
  input  logic                          predict_i,
  input  logic                          upd_valid_i,
  input  logic [IDX_W-1:0]              upd_idx_i,
  input  logic [ADDR_W-1:0]             upd_addr_i,
  output logic [DEPTH-1:0]              ready_o,
  output logic [DEPTH-1:0]              replay_o
);
  logic [DEPTH-1:0][IDX_W-1:0] age;
  logic [DEPTH-1:0]            blocked;
  logic                        upd_store;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_age
    assign age[gi] = IDX_W'(gi) - head_i;
  end

  assign upd_store = upd_valid_i && valid_i[upd_idx_i] && store_i[upd_idx_i];

  always_comb begin
    blocked  = '0;
    ready_o  = '0;
    replay_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && valid_i[j] && store_i[j] && age[j] < age[i]) begin
          // unknown older store blocks only in the safe policy
          if (addr_known_i[j] ? (addr_i[j] == addr_i[i]) : !predict_i)
            blocked[i] = 1'b1;
        end
      end
      ready_o[i] = valid_i[i] && !store_i[i] && addr_known_i[i] &&
                   !done_i[i] && !blocked[i];
      // load already read (or reading now) hit by a late older store address
      replay_o[i] = upd_store && valid_i[i] && !store_i[i] && addr_known_i[i] &&
                    (done_i[i] || issue_i[i]) && (age[upd_idx_i] < age[i]) &&
                    (addr_i[i] == upd_addr_i);
    end
  end
endmodule

// File: rtl/load_store_queue.sv
module load_store_queue
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              predict_mode_i,
  input  logic              alloc_i,
  input  logic              alloc_store_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  output logic              full_o,
  input  logic              addr_valid_i,
  input  logic [IDX_W-1:0]  addr_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [IDX_W-1:0]  data_idx_i,
  input  logic              commit_i,
  output logic              commit_done_o,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  output logic [DEPTH-1:0]  replay_mask_o
);
  lsq_flags_t                  flags_q [DEPTH];
  lsq_flags_t                  flags_d [DEPTH];
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0]            valid_v, store_v, ak_v, done_v;
  logic [DEPTH-1:0]            ready, replay, req, gnt;
  logic [IDX_W-1:0]            head, tail, gnt_idx;
  logic                        full, gnt_valid, alloc_ok, retire, store_wr;
  lsq_flags_t                  hd;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_unpack
    assign valid_v[gi] = flags_q[gi].valid;
    assign store_v[gi] = flags_q[gi].is_store;
    assign ak_v[gi]    = flags_q[gi].addr_known;
    assign done_v[gi]  = flags_q[gi].done;
  end

  assign hd       = flags_q[head];
  assign alloc_ok = alloc_i && !full;
  assign retire   = commit_i && hd.valid &&
                    (hd.is_store ? (hd.addr_known && hd.data_known) : hd.done);
  assign store_wr = retire && hd.is_store;
  assign req      = ready & ~{DEPTH{store_wr}};

  lsq_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptrs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (alloc_ok),
    .pop_i  (retire),
    .head_o (head),
    .tail_o (tail),
    .full_o (full)
  );

  lsq_hazard #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_hazard (
    .head_i       (head),
    .valid_i      (valid_v),
    .store_i      (store_v),
    .addr_known_i (ak_v),
    .done_i       (done_v),
    .issue_i      (gnt),
    .addr_i       (addr_q),
    .predict_i    (predict_mode_i),
    .upd_valid_i  (addr_valid_i),
    .upd_idx_i    (addr_idx_i),
    .upd_addr_i   (addr_i),
    .ready_o      (ready),
    .replay_o     (replay)
  );

  lsq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .head_i      (head),
    .req_i       (req),
    .gnt_o       (gnt),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      flags_d[i] = flags_q[i];
      if (gnt[i])    flags_d[i].done = 1'b1;
      if (replay[i]) flags_d[i].done = 1'b0;
      if (addr_valid_i && addr_idx_i == IDX_W'(i)) flags_d[i].addr_known = 1'b1;
      if (data_valid_i && data_idx_i == IDX_W'(i)) flags_d[i].data_known = 1'b1;
      if (retire && head == IDX_W'(i)) flags_d[i] = '0;
      if (alloc_ok && tail == IDX_W'(i))
        flags_d[i] = '{valid: 1'b1, is_store: alloc_store_i, default: 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) flags_q[i] <= '0;
      addr_q        <= '0;
      mem_valid_o   <= 1'b0;
      mem_write_o   <= 1'b0;
      mem_addr_o    <= '0;
      mem_idx_o     <= '0;
      replay_mask_o <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) flags_q[i] <= flags_d[i];
      if (addr_valid_i) addr_q[addr_idx_i] <= addr_i;
      mem_valid_o   <= store_wr || gnt_valid;
      mem_write_o   <= store_wr;
      mem_addr_o    <= store_wr ? addr_q[head] : addr_q[gnt_idx];
      mem_idx_o     <= store_wr ? head : gnt_idx;
      replay_mask_o <= replay;
    end
  end

  assign alloc_idx_o   = tail;
  assign full_o        = full;
  assign commit_done_o = retire;

  // R3
  wr_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_write_o) |-> $past(commit_i));

  // R3
  store_retire_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire && hd.is_store) |=> (mem_valid_o && mem_write_o && mem_idx_o == $past(head)));

  // R7
  replay_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|replay_mask_o) |-> $past(predict_mode_i));
endmodule

// File: tb/tb_load_store_queue.sv
module tb_load_store_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int IDX_W      = 3;
  localparam int ADDR_W     = 32;

  logic              clk, rst_n;
  logic              predict_mode, alloc, alloc_store, addr_valid, data_valid, commit;
  logic [IDX_W-1:0]  alloc_idx, addr_idx, data_idx, mem_idx;
  logic [ADDR_W-1:0] addr, mem_addr;
  logic              full, commit_done, mem_valid, mem_write;
  logic [DEPTH-1:0]  replay_mask;

  load_store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .predict_mode_i(predict_mode),
    .alloc_i(alloc), .alloc_store_i(alloc_store), .alloc_idx_o(alloc_idx),
    .full_o(full), .addr_valid_i(addr_valid), .addr_idx_i(addr_idx),
    .addr_i(addr), .data_valid_i(data_valid), .data_idx_i(data_idx),
    .commit_i(commit), .commit_done_o(commit_done), .mem_valid_o(mem_valid),
    .mem_write_o(mem_write), .mem_addr_o(mem_addr), .mem_idx_o(mem_idx),
    .replay_mask_o(replay_mask)
  );

  typedef struct { int c; bit w; int a; int i; string r; } exp_t;
  exp_t sb[$];
  exp_t cur;
  int   n_chk = 0, n_fail = 0, cyc = 0, nidx = 0, base = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string r, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, expv);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic expect_op(int c, bit w, int a, int i, string r);
    sb.push_back('{c, w, a, i, r});
  endtask

  // monitor: compare every issued request with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3/R4/R5", "unexpected request entry", mem_idx, -1);
      end else begin
        cur = sb.pop_front();
        check(cyc == cur.c, cur.r, "request cycle", cyc, cur.c);
        check(mem_write == cur.w && mem_idx == IDX_W'(cur.i), cur.r,
              "request kind/entry", {mem_write, mem_idx}, {cur.w, IDX_W'(cur.i)});
        check(mem_addr == ADDR_W'(cur.a), cur.r, "request address", mem_addr, cur.a);
      end
    end
  end

  task automatic do_alloc(bit st);
    check(alloc_idx == IDX_W'(nidx), "R1", "allocation index", alloc_idx, nidx);
    alloc = 1'b1; alloc_store = st;
    @(negedge clk);
    alloc = 1'b0;
    nidx = (nidx + 1) % DEPTH;
  endtask

  task automatic do_addr(int idx, int a);
    addr_valid = 1'b1; addr_idx = IDX_W'(idx); addr = ADDR_W'(a);
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  task automatic do_data(int idx);
    data_valid = 1'b1; data_idx = IDX_W'(idx);
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic do_commit(bit exp_done, string r);
    commit = 1'b1;
    #1;
    check(commit_done == exp_done, r, "commit_done", commit_done, exp_done);
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "R2", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; predict_mode = 1'b0; alloc = 1'b0; alloc_store = 1'b0;
    addr_valid = 1'b0; addr_idx = '0; addr = '0; data_valid = 1'b0;
    data_idx = '0; commit = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(full == 1'b0, "R1", "reset full", full, 0);
    check(mem_valid == 1'b0, "R2", "reset mem_valid", mem_valid, 0);
    check(replay_mask == '0, "R7", "reset replay mask", replay_mask, 0);

    // safe policy: L0 S1 L2 L3
    do_alloc(1'b0); do_alloc(1'b1); do_alloc(1'b0); do_alloc(1'b0);
    do_commit(1'b0, "R9");
    expect_op(cyc + 2, 1'b0, 'h10, 0, "R2");
    do_addr(0, 'h10);
    do_addr(2, 'h20);
    do_addr(3, 'h24);
    idle(3);
    check(mem_valid == 1'b0, "R4", "load waits on unknown store", mem_valid, 0);
    expect_op(cyc + 2, 1'b0, 'h20, 2, "R4");
    expect_op(cyc + 3, 1'b0, 'h24, 3, "R8");
    do_addr(1, 'h30);
    idle(3);
    do_data(1);
    do_commit(1'b1, "R9");
    expect_op(cyc + 1, 1'b1, 'h30, 1, "R3");
    do_commit(1'b1, "R3");
    do_commit(1'b1, "R9");
    do_commit(1'b1, "R9");
    idle(2);

    // safe policy, same address: S4 L5
    do_alloc(1'b1); do_alloc(1'b0);
    do_addr(4, 'h40);
    do_addr(5, 'h40);
    idle(3);
    check(mem_valid == 1'b0, "R5", "load waits on matching store", mem_valid, 0);
    do_commit(1'b0, "R3");
    do_data(4);
    expect_op(cyc + 1, 1'b1, 'h40, 4, "R3");
    expect_op(cyc + 2, 1'b0, 'h40, 5, "R5");
    do_commit(1'b1, "R3");
    idle(1);
    do_commit(1'b1, "R9");
    idle(2);

    // speculative policy: S6 L7 L0
    predict_mode = 1'b1;
    do_alloc(1'b1); do_alloc(1'b0); do_alloc(1'b0);
    expect_op(cyc + 2, 1'b0, 'h50, 7, "R6");
    do_addr(7, 'h50);
    expect_op(cyc + 2, 1'b0, 'h60, 0, "R6");
    do_addr(0, 'h60);
    idle(1);
    do_addr(6, 'h50);
    check(replay_mask == 8'h80, "R7", "replay mask", replay_mask, 8'h80);
    idle(1);
    check(replay_mask == 8'h00, "R7", "replay one cycle", replay_mask, 0);
    idle(2);
    do_data(6);
    expect_op(cyc + 1, 1'b1, 'h50, 6, "R3");
    expect_op(cyc + 2, 1'b0, 'h50, 7, "R7");
    do_commit(1'b1, "R3");
    idle(1);
    do_commit(1'b1, "R9");
    do_commit(1'b1, "R9");
    idle(2);
    predict_mode = 1'b0;

    // fill with stores, drop one allocation, drain in order
    for (int k = 0; k < DEPTH; k++) do_alloc(1'b1);
    check(full == 1'b1, "R1", "full after DEPTH allocations", full, 1);
    alloc = 1'b1; alloc_store = 1'b1;
    @(negedge clk);
    alloc = 1'b0;
    for (int k = 0; k < DEPTH; k++) do_addr((nidx + k) % DEPTH, 'h100 + k);
    for (int k = 0; k < DEPTH; k++) do_data((nidx + k) % DEPTH);
    base = cyc;
    for (int k = 0; k < DEPTH; k++)
      expect_op(base + 1 + k, 1'b1, 'h100 + k, (nidx + k) % DEPTH, "R3");
    for (int k = 0; k < DEPTH; k++) do_commit(1'b1, "R3");
    check(full == 1'b0, "R1", "empty after drain", full, 0);
    do_alloc(1'b0);
    expect_op(cyc + 2, 1'b0, 'h200, (nidx + DEPTH - 1) % DEPTH, "R1");
    do_addr((nidx + DEPTH - 1) % DEPTH, 'h200);
    idle(1);
    do_commit(1'b1, "R9");
    idle(3);

    check(sb.size() == 0, "R2", "requests still expected", sb.size(), 0);
    finish_run();
  end
endmodule